// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Merger

This block collects up to 32 interrupt sources into one status word and presents a single request line to the processor. Every bit position has a fixed type. Level positions show their input directly in the status word. Edge positions capture a rising transition in a sticky latch, and that latch stays set until software clears it. Three level positions carry the group summaries of a cascaded sub-controller, which has its own dedicated input. A software register can raise three of the edge positions on its own.

Software sees four word-wide registers, selected by a 2-bit address: status (read only), mask, edge latch and software request. The block gates the status word with the mask. It then registers the OR of the result as the processor request, along with the index of the lowest-numbered pending bit and a flag that marks the index as meaningful. Interrupt software reads the index directly instead of scanning the status word. When the flag is low it treats the event as spurious.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset the mask, edge-latch and software registers read zero, and `cpu_irq` and `vec_valid` are low.
- R2: Level positions (bits 0-3, 7-15, 20, 21, 25-27) appear in the status word (address 0) as the present value of `src_in`, with no storage.
- R3: Edge positions (bits 16-19, 22-24, 28-31) latch a 0-to-1 transition of `src_in`. The latch bit stays set after the input falls, and the status word shows the latch, not the raw input.
- R4: A write to the edge-latch register (address 2) clears every latch bit whose written value is 0. A written 1 leaves the bit unchanged and never sets it.
- R5: If a new rising edge arrives in the same cycle as a clearing write, the bit ends up set.
- R6: Status bits 4, 5 and 6 equal `casc_sum[0]`, `casc_sum[1]` and `casc_sum[2]`. `src_in[6:4]` has no effect on the status word.
- R7: The software register (address 3) stores only bits 28-30 of a write and reads zero elsewhere. Its set bits are ORed into the status word.
- R8: `cpu_irq` is the OR of (status AND mask), registered, so it follows a change of status or mask one clock edge later. The mask register is address 1.
- R9: `vec_id` is the index of the lowest-numbered set bit of (status AND mask), registered alongside `cpu_irq`. `vec_valid` is high when any bit is set, and `vec_id` is 0 when none is.
- R10: A write to address 0 changes no register. `reg_rdata` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Raw source lines, edge or level by position |
| casc_sum | input | 3 | Group summaries from the cascaded sub-controller |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 edge latch, 3 software |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| cpu_irq | output | 1 | Registered processor interrupt request |
| vec_id | output | 5 | Registered lowest pending source index |
| vec_valid | output | 1 | High when `vec_id` names a pending source |

## Verification
Any corruption of the edge latch shows up at once as a bit error on the edge-latch read. Through the request path it appears one edge later, as a wrong `cpu_irq` or `vec_id`. Two timing errors are distinguishable at the ports: an edge that latches late or not at all misses the status read taken one cycle after the pulse, and a clear that wins over a simultaneous edge loses a bit that the next read exposes. A mask or encoder fault shows as the wrong index within one cycle of the mask write. The test patterns put several pending bits above and below the masked ones, so a priority inversion cannot go unnoticed.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

    localparam int          SRC_N     = 32;
    localparam logic [31:0] EDGE_POS  = 32'hF1CF_0000;  // 16-19, 22-24, 28-31
    localparam logic [31:0] SOFT_POS  = 32'h7000_0000;  // 28-30
    localparam int          GRP_LSB   = 4;
    localparam int          GRP_N     = 3;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_LATCH  = 2'd2,
        SEL_SOFT   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int               W        = 32,
    parameter logic [W-1:0]     EDGE_MAP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         clr_en,
    input  logic [W-1:0] clr_keep,
    output logic [W-1:0] latch_q
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise_w;
    logic [W-1:0] kept_w;
    logic [W-1:0] latch_nxt;

    always_comb begin
        rise_w    = src & ~prev_q & EDGE_MAP;
        kept_w    = clr_en ? (latch_q & clr_keep) : latch_q;
        // a fresh edge is ORed after the clear so it survives it
        latch_nxt = (kept_w | rise_w) & EDGE_MAP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= src;
            latch_q <= latch_nxt;
        end
    end

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((latch_q & $past(latch_q)) == $past(latch_q))); // R3

    AST_LEVEL_NEVER_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & ~EDGE_MAP) == '0); // R2

    AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ((src & ~prev_q) == '0)) |=> ((latch_q & ~$past(latch_q)) == '0)); // R4

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ((src & ~prev_q & EDGE_MAP) != '0))
            |=> ((latch_q & $past(src & ~prev_q & EDGE_MAP)) != '0)); // R5

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
    parameter int W   = 32,
    parameter int IDW = $clog2(W)
) (
    input  logic [W-1:0]   req,
    output logic [IDW-1:0] idx,
    output logic           any
);

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IDW'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
    import irq_merge_pkg::*;
#(
    parameter int               NUM_SRC  = SRC_N,
    parameter logic [NUM_SRC-1:0] EDGE_MAP = EDGE_POS,
    parameter logic [NUM_SRC-1:0] SOFT_MAP = SOFT_POS,
    parameter int               CASC_LSB = GRP_LSB,
    parameter int               CASC_N   = GRP_N,
    localparam int              ID_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [CASC_N-1:0]  casc_sum,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               cpu_irq,
    output logic [ID_W-1:0]    vec_id,
    output logic               vec_valid
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] soft_q;
    logic [NUM_SRC-1:0] latch_w;
    logic [NUM_SRC-1:0] level_w;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] pending_w;
    logic [ID_W-1:0]    enc_idx;
    logic               enc_any;
    logic               wr_mask;
    logic               wr_latch;
    logic               wr_soft;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        wr_mask  = 1'b0;
        wr_latch = 1'b0;
        wr_soft  = 1'b0;
        unique case (sel)
            SEL_STATUS: ;
            SEL_MASK:   wr_mask  = reg_wr;
            SEL_LATCH:  wr_latch = reg_wr;
            SEL_SOFT:   wr_soft  = reg_wr;
        endcase
    end

    irq_edge_latch #(.W(NUM_SRC), .EDGE_MAP(EDGE_MAP)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_in),
        .clr_en   (wr_latch),
        .clr_keep (reg_wdata),
        .latch_q  (latch_w)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i >= CASC_LSB && i < CASC_LSB + CASC_N) begin : g_casc
            assign level_w[i] = casc_sum[i-CASC_LSB];
        end else if (EDGE_MAP[i]) begin : g_edge
            assign level_w[i] = 1'b0;
        end else begin : g_lvl
            assign level_w[i] = src_in[i];
        end
    end

    assign status_w  = level_w | latch_w | soft_q;
    assign pending_w = status_w & mask_q;

    irq_lowest_enc #(.W(NUM_SRC), .IDW(ID_W)) u_enc (
        .req (pending_w),
        .idx (enc_idx),
        .any (enc_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            soft_q    <= '0;
            cpu_irq   <= 1'b0;
            vec_id    <= '0;
            vec_valid <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= reg_wdata;
            if (wr_soft) soft_q <= reg_wdata & SOFT_MAP;
            cpu_irq   <= enc_any;
            vec_id    <= enc_idx;
            vec_valid <= enc_any;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status_w;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_LATCH:  reg_rdata = latch_w;
            SEL_SOFT:   reg_rdata = soft_q;
        endcase
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !cpu_irq); // R8

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (($past(pending_w) &
                        ((NUM_SRC'(1) << vec_id) - NUM_SRC'(1))) == '0)); // R9

    AST_VEC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (((($past(mask_q) >> vec_id)) & NUM_SRC'(1)) != '0)); // R9

    AST_STATUS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_STATUS) |=> ($stable(mask_q) && $stable(soft_q))); // R10

endmodule

// File: tb/irq_merge_ctrl_tb.sv
module irq_merge_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [2:0]  casc_sum = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq;
    logic [4:0]  vec_id;
    logic        vec_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] LVL_BITS = ~(32'hF1CF_0000 | 32'h0000_0070);

    typedef struct packed {
        logic [31:0] src;
        logic [2:0]  casc;
        logic [31:0] mask;
        logic        irq;
        logic [4:0]  vec;
    } row_t;

    localparam row_t TBL [8] = '{
        '{32'h0000_0001, 3'b000, 32'hFFFF_FFFF, 1'b1, 5'd0},
        '{32'h0000_0F80, 3'b000, 32'hFFFF_FF7F, 1'b1, 5'd8},
        '{32'h0030_0000, 3'b000, 32'h0020_0000, 1'b1, 5'd21},
        '{32'h0E00_0000, 3'b000, 32'h0000_0000, 1'b0, 5'd0},
        '{32'h0000_0070, 3'b100, 32'h0000_0070, 1'b1, 5'd6},
        '{32'h0000_8000, 3'b000, 32'h0000_8000, 1'b1, 5'd15},
        '{32'h0000_0000, 3'b011, 32'h0000_0030, 1'b1, 5'd4},
        '{32'h0200_0404, 3'b000, 32'h0200_0400, 1'b1, 5'd10}
    };

    irq_merge_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .casc_sum  (casc_sum),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_irq   (cpu_irq),
        .vec_id    (vec_id),
        .vec_valid (vec_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_src(input logic [31:0] bits);
        src_in = bits;
        @(negedge clk);
        src_in = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_reg(2'd1, rv); chk("R1 mask", rv, 32'h0);
        read_reg(2'd2, rv); chk("R1 latch", rv, 32'h0);
        read_reg(2'd3, rv); chk("R1 soft", rv, 32'h0);
        read_reg(2'd0, rv); chk("R1 status", rv, 32'h0);
        chk("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
        chk("R1 vec_valid", {31'd0, vec_valid}, 32'd0);

        // vector table: R2 level status, R6 cascade, R8 request, R9 index
        for (int k = 0; k < 8; k++) begin
            write_reg(2'd1, TBL[k].mask);
            src_in   = TBL[k].src;
            casc_sum = TBL[k].casc;
            @(negedge clk);
            chk("R8 cpu_irq row", {31'd0, cpu_irq}, {31'd0, TBL[k].irq});
            chk("R9 vec_valid row", {31'd0, vec_valid}, {31'd0, TBL[k].irq});
            chk("R9 vec_id row", {27'd0, vec_id}, {27'd0, TBL[k].vec});
            read_reg(2'd0, rv);
            chk("R2 R6 status row", rv,
                (TBL[k].src & LVL_BITS) | ({29'd0, TBL[k].casc} << 4));
        end

        src_in = '0; casc_sum = '0;
        write_reg(2'd1, 32'h0);
        @(negedge clk);

        // R3 edge capture sticks after input falls
        pulse_src(32'h0002_0000);
        @(negedge clk);
        read_reg(2'd2, rv); chk("R3 latch after pulse", rv, 32'h0002_0000);
        read_reg(2'd0, rv); chk("R3 status shows latch", rv, 32'h0002_0000);
        chk("R8 masked request low", {31'd0, cpu_irq}, 32'd0);

        // R8 one-edge latency after mask write
        write_reg(2'd1, 32'h0002_0000);
        chk("R8 latency not yet", {31'd0, cpu_irq}, 32'd0);
        @(negedge clk);
        chk("R8 request after mask", {31'd0, cpu_irq}, 32'd1);
        chk("R9 vec edge source", {27'd0, vec_id}, 32'd17);

        // R4 writing ones keeps, writing zero clears
        write_reg(2'd2, 32'hFFFF_FFFF);
        read_reg(2'd2, rv); chk("R4 ones keep", rv, 32'h0002_0000);
        pulse_src(32'h0040_0000);
        write_reg(2'd2, 32'hFFFD_FFFF);
        read_reg(2'd2, rv); chk("R4 selective clear", rv, 32'h0040_0000);
        @(negedge clk);
        chk("R4 request drops", {31'd0, cpu_irq}, 32'd0);

        // R5 edge and clear together
        reg_addr  = 2'd2;
        reg_wdata = 32'h0;
        reg_wr    = 1'b1;
        src_in    = 32'h0004_0000;
        @(negedge clk);
        reg_wr    = 1'b0;
        read_reg(2'd2, rv); chk("R5 edge wins", rv, 32'h0004_0000);
        src_in = '0;
        write_reg(2'd2, 32'h0);

        // R7 software register
        write_reg(2'd3, 32'hFFFF_FFFF);
        read_reg(2'd3, rv); chk("R7 soft confined", rv, 32'h7000_0000);
        read_reg(2'd0, rv); chk("R7 soft in status", rv, 32'h7000_0000);
        write_reg(2'd1, 32'h3000_0000);
        @(negedge clk);
        chk("R7 soft request", {31'd0, cpu_irq}, 32'd1);
        chk("R9 vec soft", {27'd0, vec_id}, 32'd28);

        // R10 status is read only
        read_reg(2'd0, s0);
        write_reg(2'd0, 32'h0);
        read_reg(2'd0, rv); chk("R10 status unchanged", rv, s0);
        read_reg(2'd1, rv); chk("R10 mask unchanged", rv, 32'h3000_0000);

        // R6 raw src_in[6:4] has no effect
        write_reg(2'd3, 32'h0);
        write_reg(2'd1, 32'h0000_0070);
        src_in = 32'h0000_0070;
        @(negedge clk);
        chk("R6 src ignored request", {31'd0, vec_valid}, 32'd0);
        read_reg(2'd0, rv); chk("R6 src ignored status", rv, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule